// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This block is an opcode-selected execution unit for a 32-bit datapath. Each accepted request carries an opcode and two source words. One result word comes back on the following clock edge. The operations cover the following:

- AND with an inverted operand
- the lowest-set-bit family: isolate, mask below, clear
- clearing the high bits from an index upward
- extracting a right-aligned field, with its start and length packed into one control word
- leading-zero, trailing-zero and population counts
- a rotate and three shifts that leave the flags alone

The unit has two flag outputs, a zero flag and a carry flag. Most operations update them. The shift group and unassigned opcodes leave them untouched. This lets a scheduler place those instructions without adding a flag dependency. A caller presents `in_valid` with the operands and reads `out_valid`, `out_result` and the flags one cycle later. The unit can take a new request every cycle.

Top module: `bmu_core`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. When `in_valid` is low, `out_result`, `out_zf` and `out_cf` keep their values. Synchronous reset drives `out_valid`, `out_result`, `out_zf` and `out_cf` to 0.
- R2: Opcode 0 returns `in_a & ~in_b`.
- R3: Opcodes 1, 2 and 3 act on `in_a`.
  - Opcode 1 returns only its lowest 1 bit.
  - Opcode 2 returns that bit together with every bit below it set to 1. A zero source gives all ones.
  - Opcode 3 returns `in_a` with its lowest 1 bit cleared.
- R4: Opcode 4 uses `in_b[7:0]` as an index n. It returns `in_a` with bits n and above cleared. An n of 32 or more returns `in_a` unchanged. Bits 31:8 of `in_b` are ignored.
- R5: Opcode 5 extracts a field from `in_a` and returns it right-aligned.
  - The start bit is `in_b[7:0]` and the length is `in_b[15:8]`.
  - A start of 32 or more gives 0, and so does a length of 0.
  - Bits past bit 31 read as zero.
- R6: Opcode 6 returns the number of zeros above the highest 1 of `in_a`. Opcode 7 returns the number of zeros below its lowest 1. For a zero source both return 32 and set `out_cf`.
- R7: Opcode 8 returns the number of 1 bits in `in_a`.
- R8: Opcodes 9 to 12 take their count from `in_b[4:0]` only.
  - 9 rotates `in_a` right.
  - 10 shifts it right arithmetically.
  - 11 shifts it left logically.
  - 12 shifts it right logically.
- R9: Flag update rules:
  - Opcodes 0 to 8 set `out_zf` when the result is zero.
  - They set `out_cf` only for opcode 6 or 7 with a zero source, and clear it otherwise.
  - Opcodes 9 to 12 leave both flags unchanged.
- R10: Opcodes 13 to 15 return 0 and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First source word |
| in_b | input | 32 | Second source or control word |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Registered result |
| out_zf | output | 1 | Zero flag |
| out_cf | output | 1 | Carry flag |

## Verification
Random operands exercise every opcode, including the unassigned ones. For the field and index operations, the control bytes are drawn near and beyond 32 so that the in-range, truncated and out-of-range paths are all hit.

Directed cases cover the inputs where counting and lowest-bit logic commonly break:
- zero, all-ones and single-bit sources separate the zero-source carry from the ordinary count
- a shift that follows a flag-writing operation shows that the flags are held rather than recomputed
- an index with high bits set separates an 8-bit index decode from a full-word decode
- idle cycles with changing operands show that the output register holds

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int XLEN    = 32;
    localparam int SHAMT_W = $clog2(XLEN);
    localparam int CNT_W   = $clog2(XLEN) + 1;
    localparam int CTRL_W  = 8;
    localparam int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ANDN    = 4'd0,
        OP_LOW_ISO = 4'd1,
        OP_LOW_MSK = 4'd2,
        OP_LOW_CLR = 4'd3,
        OP_ZERO_HI = 4'd4,
        OP_FIELD   = 4'd5,
        OP_LEAD_Z  = 4'd6,
        OP_TRAIL_Z = 4'd7,
        OP_POP     = 4'd8,
        OP_ROT_R   = 4'd9,
        OP_SHR_A   = 4'd10,
        OP_SHL_L   = 4'd11,
        OP_SHR_L   = 4'd12
    } bmu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            wr_flags;
        logic            zf;
        logic            cf;
    } bmu_res_t;

    function automatic logic op_is_shift(logic [OP_W-1:0] op);
        return (op >= OP_ROT_R) && (op <= OP_SHR_L);
    endfunction

    function automatic logic op_writes_flags(logic [OP_W-1:0] op);
        return op <= OP_POP;
    endfunction

    function automatic logic op_is_count_z(logic [OP_W-1:0] op);
        return (op == OP_LEAD_Z) || (op == OP_TRAIL_Z);
    endfunction

endpackage

// File: rtl/bmu_logic.sv
module bmu_logic
    import bmu_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IDX_W = CTRL_W
) (
    input  bmu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int SH_W = $clog2(W);
    localparam logic [IDX_W-1:0] W_IDX = IDX_W'(W);

    logic [W-1:0]     a_dec;
    logic [W-1:0]     iso;
    logic [W-1:0]     msk;
    logic [W-1:0]     clr;
    logic [W-1:0]     zhi;
    logic [IDX_W-1:0] idx;

    assign a_dec = a - W'(1);
    assign iso   = a & ~a_dec;
    assign msk   = a ^ a_dec;
    assign clr   = a & a_dec;
    assign idx   = b[IDX_W-1:0];

    always_comb begin
        if (idx >= W_IDX) begin
            zhi = a;
        end else begin
            zhi = a & ~({W{1'b1}} << idx[SH_W-1:0]);
        end
    end

    always_comb begin
        unique case (op)
            OP_ANDN:    y = a & ~b;
            OP_LOW_ISO: y = iso;
            OP_LOW_MSK: y = msk;
            OP_LOW_CLR: y = clr;
            OP_ZERO_HI: y = zhi;
            default:    y = '0;
        endcase
    end

endmodule

// File: rtl/bmu_extract.sv
module bmu_extract
    import bmu_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IDX_W = CTRL_W
) (
    input  logic [W-1:0]         a,
    input  logic [2*IDX_W-1:0]   ctrl,
    output logic [W-1:0]         y
);
    localparam int SH_W = $clog2(W);
    localparam logic [IDX_W-1:0] W_IDX = IDX_W'(W);

    logic [IDX_W-1:0] start;
    logic [IDX_W-1:0] len;
    logic [W-1:0]     shifted;
    logic [W-1:0]     keep;

    assign start = ctrl[IDX_W-1:0];
    assign len   = ctrl[2*IDX_W-1:IDX_W];

    always_comb begin
        shifted = '0;
        keep    = '0;
        if (start < W_IDX) begin
            shifted = a >> start[SH_W-1:0];
        end
        if (len >= W_IDX) begin
            keep = '1;
        end else begin
            keep = ~({W{1'b1}} << len[SH_W-1:0]);
        end
    end

    assign y = (len == '0) ? '0 : (shifted & keep);

endmodule

// File: rtl/bmu_count.sv
module bmu_count
    import bmu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  bmu_op_e        op,
    input  logic [W-1:0]   a,
    output logic [W-1:0]   y
);
    localparam int CW = $clog2(W) + 1;

    logic [CW-1:0] lz;
    logic [CW-1:0] tz;
    logic [CW-1:0] pop;

    always_comb begin
        lz = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (a[i]) lz = CW'(W - 1 - i);
        end
    end

    always_comb begin
        tz = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (a[i]) tz = CW'(i);
        end
    end

    always_comb begin
        pop = '0;
        for (int i = 0; i < W; i++) begin
            pop = pop + CW'(a[i]);
        end
    end

    always_comb begin
        unique case (op)
            OP_LEAD_Z:  y = {{(W-CW){1'b0}}, lz};
            OP_TRAIL_Z: y = {{(W-CW){1'b0}}, tz};
            OP_POP:     y = {{(W-CW){1'b0}}, pop};
            default:    y = '0;
        endcase
    end

endmodule

// File: rtl/bmu_shift.sv
module bmu_shift
    import bmu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  bmu_op_e                 op,
    input  logic [W-1:0]            a,
    input  logic [$clog2(W)-1:0]    amt,
    output logic [W-1:0]            y
);
    logic [W-1:0] ror;
    logic [W-1:0] sar;
    logic [W-1:0] shl;
    logic [W-1:0] shr;

    assign ror = (a >> amt) | (a << (W - int'(amt)));
    assign sar = $unsigned($signed(a) >>> amt);
    assign shl = a << amt;
    assign shr = a >> amt;

    always_comb begin
        unique case (op)
            OP_ROT_R: y = ror;
            OP_SHR_A: y = sar;
            OP_SHL_L: y = shl;
            OP_SHR_L: y = shr;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/bmu_core.sv
module bmu_core
    import bmu_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IDX_W = CTRL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    in_op,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    output logic          out_valid,
    output logic [W-1:0]  out_result,
    output logic          out_zf,
    output logic          out_cf
);
    localparam int SH_W = $clog2(W);

    bmu_op_e      op;
    logic [W-1:0] y_logic;
    logic [W-1:0] y_field;
    logic [W-1:0] y_count;
    logic [W-1:0] y_shift;
    bmu_res_t     nxt;

    assign op = bmu_op_e'(in_op);

    bmu_logic #(.W(W), .IDX_W(IDX_W)) u_logic (
        .op (op),
        .a  (in_a),
        .b  (in_b),
        .y  (y_logic)
    );

    bmu_extract #(.W(W), .IDX_W(IDX_W)) u_extract (
        .a    (in_a),
        .ctrl (in_b[2*IDX_W-1:0]),
        .y    (y_field)
    );

    bmu_count #(.W(W)) u_count (
        .op (op),
        .a  (in_a),
        .y  (y_count)
    );

    bmu_shift #(.W(W)) u_shift (
        .op  (op),
        .a   (in_a),
        .amt (in_b[SH_W-1:0]),
        .y   (y_shift)
    );

    always_comb begin
        nxt = '0;
        unique case (op)
            OP_ANDN, OP_LOW_ISO, OP_LOW_MSK, OP_LOW_CLR, OP_ZERO_HI:
                nxt.value = y_logic;
            OP_FIELD:
                nxt.value = y_field;
            OP_LEAD_Z, OP_TRAIL_Z, OP_POP:
                nxt.value = y_count;
            OP_ROT_R, OP_SHR_A, OP_SHL_L, OP_SHR_L:
                nxt.value = y_shift;
            default:
                nxt.value = '0;
        endcase
        nxt.wr_flags = op_writes_flags(in_op);
        nxt.zf       = (nxt.value == '0);
        nxt.cf       = op_is_count_z(in_op) && (in_a == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_zf     <= 1'b0;
            out_cf     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= nxt.value;
                if (nxt.wr_flags) begin
                    out_zf <= nxt.zf;
                    out_cf <= nxt.cf;
                end
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                              // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));                   // R1
    AST_ZERO_SRC_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_is_count_z(in_op) && in_a == '0)
        |=> (out_cf && out_result == W));                                     // R6
    AST_SHIFT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_is_shift(in_op)) |=> ($stable(out_zf) && $stable(out_cf))); // R9
    AST_ZF_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_writes_flags(in_op)) |=> (out_zf == (out_result == '0))); // R9
    AST_SPARE_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > 4'd12) |=> (out_result == '0 && $stable(out_zf))); // R10

endmodule

// File: tb/bmu_core_tb.sv
`timescale 1ns/1ps
module bmu_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_zf;
    logic        out_cf;

    int checks = 0;
    int failures = 0;
    logic m_zf = 1'b0;
    logic m_cf = 1'b0;

    always #10 clk = ~clk;

    bmu_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_zf     (out_zf),
        .out_cf     (out_cf)
    );

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [31:0] r = '0;
        int n;
        int s;
        int l;
        bit found = 0;
        case (op)
            4'd0: r = a & ~b;
            4'd1: for (int i = 0; i < 32; i++) if (!found && a[i]) begin r[i] = 1'b1; found = 1; end
            4'd2: begin
                for (int i = 0; i < 32; i++) if (!found) begin r[i] = 1'b1; if (a[i]) found = 1; end
            end
            4'd3: begin
                r = a;
                for (int i = 0; i < 32; i++) if (!found && a[i]) begin r[i] = 1'b0; found = 1; end
            end
            4'd4: begin
                n = int'(b[7:0]);
                for (int i = 0; i < 32; i++) if (i < n) r[i] = a[i];
            end
            4'd5: begin
                s = int'(b[7:0]);
                l = int'(b[15:8]);
                for (int i = 0; i < 32; i++) if (i < l && s + i < 32) r[i] = a[s+i];
            end
            4'd6: begin n = 0; for (int i = 31; i >= 0; i--) begin if (a[i]) break; n++; end r = 32'(n); end
            4'd7: begin n = 0; for (int i = 0; i < 32; i++) begin if (a[i]) break; n++; end r = 32'(n); end
            4'd8: begin n = 0; for (int i = 0; i < 32; i++) if (a[i]) n++; r = 32'(n); end
            4'd9: begin n = int'(b[4:0]); for (int i = 0; i < 32; i++) r[i] = a[(i+n)%32]; end
            4'd10: begin n = int'(b[4:0]); for (int i = 0; i < 32; i++) r[i] = (i+n < 32) ? a[i+n] : a[31]; end
            4'd11: begin n = int'(b[4:0]); for (int i = 0; i < 32; i++) r[i] = (i >= n) ? a[i-n] : 1'b0; end
            4'd12: begin n = int'(b[4:0]); for (int i = 0; i < 32; i++) r[i] = (i+n < 32) ? a[i+n] : 1'b0; end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input string tag);
        logic [31:0] exp;
        exp = model(op, a, b);
        if (op <= 4'd8) begin
            m_zf = (exp == 32'd0);
            m_cf = (op == 4'd6 || op == 4'd7) && (a == 32'd0);
        end
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, tag, "valid", 32'(out_valid), 32'd1);
        check(out_result == exp, tag, "result", out_result, exp);
        check(out_zf == m_zf, tag, "zf", 32'(out_zf), 32'(m_zf));
        check(out_cf == m_cf, tag, "cf", 32'(out_cf), 32'(m_cf));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] held;
        logic [3:0]  rop;
        logic [31:0] ra;
        logic [31:0] rb;
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1", "reset valid", 32'(out_valid), 32'd0);
        check(out_result == 32'd0, "R1", "reset result", out_result, 32'd0);
        check({out_zf, out_cf} == 2'b00, "R1", "reset flags", 32'({out_zf, out_cf}), 32'd0);
        rst = 1'b0;

        run_op(4'd0, 32'hF0F0_1234, 32'h0FF0_0204, "R2");
        run_op(4'd1, 32'h0001_8A00, 32'h0, "R3");
        run_op(4'd2, 32'h0001_8A00, 32'h0, "R3");
        run_op(4'd2, 32'h0, 32'h0, "R3");
        run_op(4'd3, 32'h8000_0000, 32'h0, "R3");
        run_op(4'd1, 32'h0, 32'h0, "R3");
        run_op(4'd4, 32'hFFFF_FFFF, 32'h0000_0000, "R4");
        run_op(4'd4, 32'hFFFF_FFFF, 32'h0000_0020, "R4");
        run_op(4'd4, 32'hDEAD_BEEF, 32'h0000_0105, "R4");
        run_op(4'd4, 32'hDEAD_BEEF, 32'h0000_00C8, "R4");
        run_op(4'd5, 32'hDEAD_BEEF, 32'h0000_0804, "R5");
        run_op(4'd5, 32'hDEAD_BEEF, 32'h0000_0820, "R5");
        run_op(4'd5, 32'hDEAD_BEEF, 32'h0000_0004, "R5");
        run_op(4'd5, 32'hDEAD_BEEF, 32'h0000_FF1C, "R5");
        run_op(4'd6, 32'h0, 32'h0, "R6");
        run_op(4'd7, 32'h0, 32'h0, "R6");
        run_op(4'd6, 32'h0000_0100, 32'h0, "R6");
        run_op(4'd7, 32'h8000_0000, 32'h0, "R6");
        run_op(4'd8, 32'hFFFF_FFFF, 32'h0, "R7");
        run_op(4'd8, 32'h0, 32'h0, "R7");
        run_op(4'd9, 32'h8000_0001, 32'h0000_0021, "R8");
        run_op(4'd10, 32'h8000_0000, 32'hFFFF_FFE4, "R8");
        run_op(4'd11, 32'h0000_0001, 32'h0000_003F, "R8");
        run_op(4'd12, 32'hFFFF_FFFF, 32'h0000_0040, "R8");
        // R9 flags set then held across shifts
        run_op(4'd6, 32'h0, 32'h0, "R9");
        run_op(4'd11, 32'h0000_0001, 32'h0000_0004, "R9");
        run_op(4'd8, 32'h0, 32'h0, "R9");
        run_op(4'd9, 32'h1234_5678, 32'h0000_0008, "R9");
        run_op(4'd13, 32'hFFFF_FFFF, 32'h1, "R10");
        run_op(4'd15, 32'h1234_5678, 32'h1, "R10");

        // R1 idle cycle with changing inputs holds the result
        held = out_result;
        @(negedge clk);
        in_a = 32'hAAAA_5555; in_op = 4'd8;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "idle valid", 32'(out_valid), 32'd0);
        check(out_result == held, "R1", "idle hold", out_result, held);

        for (int k = 0; k < 400; k++) begin
            rop = 4'($urandom_range(0, 15));
            ra  = $urandom;
            case ($urandom_range(0, 3))
                0: ra = 32'd0;
                1: ra = ra & $urandom;
                default: ;
            endcase
            rb = $urandom;
            if (rop == 4'd4 || rop == 4'd5) begin
                rb[7:0]  = 8'($urandom_range(0, 40));
                rb[15:8] = 8'($urandom_range(0, 40));
            end
            run_op(rop, ra, rb, (rop <= 4'd8) ? "R9" : (rop <= 4'd12 ? "R8" : "R10"));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule